// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A purely combinational integer arithmetic/logic unit for the execute stage of a load/store RISC pipeline. It takes two operands and a 4-bit operation code. It returns a result word, a carry-out, a signed-overflow flag and a zero flag. Immediates arrive already extended, so the unit only ever sees two full-width register-style operands. Multiply, divide and shifts are handled elsewhere.

The datapath is a row of identical one-bit slices. Each slice holds a full adder, a small logic unit and an output multiplexer. The carry ripples from the least significant slice to the most significant one. Subtraction inverts B inside every slice and injects a carry of 1 into the bottom slice. The top slice feeds extra logic that forms the overflow flag, the carry output and the less-than decision. That decision is routed back into bit 0 of the result for the set-less-than operations. A wide NOR over the result word produces the zero flag.

Top module: `alu_core`

## Requirements
- R1: Code 0 (signed add) and code 1 (unsigned add) return (A + B) mod 2^32. The carry output is bit 32 of the full sum.
- R2: Code 2 (signed subtract) and code 3 (unsigned subtract) return (A + ~B + 1) mod 2^32. The carry output is 1 exactly when A >= B as unsigned numbers.
- R3: The overflow flag can be 1 only under codes 0 and 2. Under those codes it is 1 exactly when the two's-complement result differs from the true signed sum or difference. Codes 1 and 3 never raise it.
- R4: Under code 0, operands whose sign bits differ never raise overflow.
- R5: Codes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT(A OR B) respectively, using B unmodified.
- R6: Code 4'hA (signed set-less-than) returns 1 in bit 0 when A < B as signed numbers, including when A - B overflows. All other result bits are 0.
- R7: Code 4'hB (unsigned set-less-than) returns 1 in bit 0 when A < B as unsigned numbers. All other result bits are 0.
- R8: For codes 0-7, 4'hA and 4'hB, the zero flag is 1 exactly when all 32 result bits are 0.
- R9: Codes 8, 9 and 4'hC-4'hF return a zero result with the carry, overflow and zero flags all 0.
- R10: The carry output is 0 for codes 4-7, 4'hA and 4'hB. Under those codes the overflow flag is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| mode_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |
| carry_o | output | 1 | Carry out of the top slice (add/subtract codes only) |
| ovf_o | output | 1 | Signed overflow (codes 0 and 2 only) |
| zero_o | output | 1 | Result is all zero (valid codes only) |

## Verification
The in-design assertions are immediate checks evaluated whenever the inputs change. They assume all three inputs are fully known two-state values and that the outputs have settled from one input set before being judged. The bench changes operands and code together, once per clock, and holds them until the compare point half a period later. Stimulus covers every one of the sixteen codes, including the unused ones. Each code is applied to directed corner operands: the most negative value, the all-ones value, equal operands, and sign-mixed pairs. Each code is also applied to a stream of pseudo-random words from a shift register.

// File: rtl/alu_pkg.sv
// Package: shared operation codes, slice output selects and the decoded
// control bundle for the bit-sliced ALU.
package alu_pkg;

    // Operation codes presented on mode_i.
    typedef enum logic [3:0] {
        MD_ADD  = 4'h0,
        MD_ADDU = 4'h1,
        MD_SUB  = 4'h2,
        MD_SUBU = 4'h3,
        MD_AND  = 4'h4,
        MD_OR   = 4'h5,
        MD_XOR  = 4'h6,
        MD_NOR  = 4'h7,
        MD_SLT  = 4'hA,
        MD_SLTU = 4'hB
    } alu_mode_e;

    // What each slice drives onto its result bit.
    typedef enum logic [2:0] {
        SEL_SUM  = 3'd0,
        SEL_AND  = 3'd1,
        SEL_OR   = 3'd2,
        SEL_XOR  = 3'd3,
        SEL_NOR  = 3'd4,
        SEL_LESS = 3'd5,
        SEL_NONE = 3'd6
    } slice_sel_e;

    // Decoded control shared by the slices and the top-slice logic.
    typedef struct packed {
        slice_sel_e sel;        // slice output select
        logic       inv_b;      // invert B into the adders
        logic       cin0;       // carry injected into bit 0
        logic       ovf_en;     // signed arithmetic: report overflow
        logic       carry_en;   // arithmetic: report carry out
        logic       slt_signed; // set-less-than compares signed
        logic       valid;      // code is a defined operation
    } alu_ctl_t;

endpackage

// File: rtl/alu_decode.sv
// Module: alu_decode
// Turns the 4-bit operation code into the control bundle.
// Assumes: mode_i is two-state; undefined codes select no output and
// clear every enable so the result and flags come out as zero.
module alu_decode
    import alu_pkg::*;
(
    input  logic [3:0] mode_i,
    output alu_ctl_t   ctl_o
);

    // Purpose: map each code onto slice select, inversion and flag enables.
    always_comb begin
        ctl_o = '{sel: SEL_NONE, inv_b: 1'b0, cin0: 1'b0, ovf_en: 1'b0,
                  carry_en: 1'b0, slt_signed: 1'b0, valid: 1'b0};
        case (mode_i)
            MD_ADD: begin
                ctl_o.sel      = SEL_SUM;
                ctl_o.ovf_en   = 1'b1;
                ctl_o.carry_en = 1'b1;
                ctl_o.valid    = 1'b1;
            end
            MD_ADDU: begin
                ctl_o.sel      = SEL_SUM;
                ctl_o.carry_en = 1'b1;
                ctl_o.valid    = 1'b1;
            end
            MD_SUB: begin
                ctl_o.sel      = SEL_SUM;
                ctl_o.inv_b    = 1'b1;
                ctl_o.cin0     = 1'b1;
                ctl_o.ovf_en   = 1'b1;
                ctl_o.carry_en = 1'b1;
                ctl_o.valid    = 1'b1;
            end
            MD_SUBU: begin
                ctl_o.sel      = SEL_SUM;
                ctl_o.inv_b    = 1'b1;
                ctl_o.cin0     = 1'b1;
                ctl_o.carry_en = 1'b1;
                ctl_o.valid    = 1'b1;
            end
            MD_AND: begin
                ctl_o.sel   = SEL_AND;
                ctl_o.valid = 1'b1;
            end
            MD_OR: begin
                ctl_o.sel   = SEL_OR;
                ctl_o.valid = 1'b1;
            end
            MD_XOR: begin
                ctl_o.sel   = SEL_XOR;
                ctl_o.valid = 1'b1;
            end
            MD_NOR: begin
                ctl_o.sel   = SEL_NOR;
                ctl_o.valid = 1'b1;
            end
            MD_SLT: begin
                ctl_o.sel        = SEL_LESS;
                ctl_o.inv_b      = 1'b1;
                ctl_o.cin0       = 1'b1;
                ctl_o.slt_signed = 1'b1;
                ctl_o.valid      = 1'b1;
            end
            MD_SLTU: begin
                ctl_o.sel   = SEL_LESS;
                ctl_o.inv_b = 1'b1;
                ctl_o.cin0  = 1'b1;
                ctl_o.valid = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_slice.sv
// Module: alu_slice
// One bit of the ALU: full adder on A and (optionally inverted) B, a small
// logic unit on A and the raw B, and a multiplexer choosing the result bit.
// Assumes: less_i is only meaningful on bit 0; other slices tie it low.
module alu_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    input  logic       inv_b_i,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    output logic       sum_o,
    output logic       cout_o,
    output logic       res_o
);

    logic b_eff;

    // Purpose: conditional inversion of B for the subtract path.
    always_comb b_eff = b_i ^ inv_b_i;

    // Purpose: full adder sum and majority carry.
    always_comb begin
        sum_o  = a_i ^ b_eff ^ cin_i;
        cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    end

    // Purpose: pick the slice's result bit.
    always_comb begin
        case (sel_i)
            SEL_SUM:  res_o = sum_o;
            SEL_AND:  res_o = a_i & b_i;
            SEL_OR:   res_o = a_i | b_i;
            SEL_XOR:  res_o = a_i ^ b_i;
            SEL_NOR:  res_o = ~(a_i | b_i);
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_top_bit.sv
// Module: alu_top_bit
// Extra logic behind the most significant slice: overflow from the carries
// around that slice, the carry flag, and the less-than decision fed to bit 0.
// Assumes: the subtract path is active whenever a set-less-than is selected.
module alu_top_bit
    import alu_pkg::*;
(
    input  logic     cin_msb_i,
    input  logic     cout_msb_i,
    input  logic     sum_msb_i,
    input  alu_ctl_t ctl_i,
    output logic     ovf_o,
    output logic     carry_o,
    output logic     less_o
);

    logic raw_ovf;

    // Purpose: signed overflow is a mismatch of carries around the top bit.
    always_comb raw_ovf = cin_msb_i ^ cout_msb_i;

    // Purpose: gate flags by the decoded operation class.
    always_comb begin
        ovf_o   = raw_ovf & ctl_i.ovf_en;
        carry_o = cout_msb_i & ctl_i.carry_en;
    end

    // Purpose: signed compare corrects the sign by overflow; unsigned uses borrow.
    always_comb begin
        if (ctl_i.slt_signed) less_o = sum_msb_i ^ raw_ovf;
        else                  less_o = ~cout_msb_i;
    end

endmodule

// File: rtl/alu_zero_detect.sv
// Module: alu_zero_detect
// Wide NOR over the result word, qualified by a defined operation code.
// Assumes: WIDTH is at least 1.
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    input  logic             valid_i,
    output logic             zero_o
);

    // Purpose: flag an all-zero word for defined codes only.
    always_comb zero_o = valid_i & ~(|word_i);

endmodule

// File: rtl/alu_core.sv
// Module: alu_core
// Combinational bit-sliced ALU: decode, a ripple row of WIDTH slices, the
// top-bit extra logic and zero detection. Checks on port relations sit at
// the end as immediate assertions.
// Assumes: all inputs are two-state and stable while the outputs are used.
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       mode_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o
);

    localparam int MSB = WIDTH - 1;

    alu_ctl_t         ctl;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] sum_w;
    logic             less_w;

    alu_decode u_dec (
        .mode_i (mode_i),
        .ctl_o  (ctl)
    );

    // Purpose: inject the bottom carry from the decoded control.
    always_comb chain[0] = ctl.cin0;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_slice
            logic less_in;
            if (gi == 0) begin : g_lsb
                always_comb less_in = less_w;
            end else begin : g_upper
                always_comb less_in = 1'b0;
            end
            alu_slice u_bit (
                .a_i     (a_i[gi]),
                .b_i     (b_i[gi]),
                .cin_i   (chain[gi]),
                .inv_b_i (ctl.inv_b),
                .less_i  (less_in),
                .sel_i   (ctl.sel),
                .sum_o   (sum_w[gi]),
                .cout_o  (chain[gi+1]),
                .res_o   (result_o[gi])
            );
        end
    endgenerate

    alu_top_bit u_top (
        .cin_msb_i  (chain[MSB]),
        .cout_msb_i (chain[WIDTH]),
        .sum_msb_i  (sum_w[MSB]),
        .ctl_i      (ctl),
        .ovf_o      (ovf_o),
        .carry_o    (carry_o),
        .less_o     (less_w)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word_i  (result_o),
        .valid_i (ctl.valid),
        .zero_o  (zero_o)
    );

    // Purpose: port-level invariants checked whenever inputs change.
    always_comb begin
        if (mode_i != MD_ADD && mode_i != MD_SUB)
            p_ovf_signed_only_r3: assert (!ovf_o)
                else $error("overflow outside signed add/sub");
        if (mode_i == MD_ADD && a_i[MSB] != b_i[MSB])
            p_mixed_sign_r4: assert (!ovf_o)
                else $error("mixed-sign add overflowed");
        if (mode_i == MD_SLT)
            p_slt_signed_r6: assert (result_o == WIDTH'($signed(a_i) < $signed(b_i)))
                else $error("signed less-than wrong");
        if (mode_i == MD_SLTU)
            p_slt_unsigned_r7: assert (result_o == WIDTH'(a_i < b_i))
                else $error("unsigned less-than wrong");
        if (zero_o)
            p_zero_word_r8: assert (result_o == '0)
                else $error("zero flag with nonzero result");
        if (mode_i == 4'h8 || mode_i == 4'h9 || mode_i >= 4'hC)
            p_unused_clear_r9: assert (result_o == '0 && !carry_o && !ovf_o && !zero_o)
                else $error("unused code produced output");
        if ((mode_i >= MD_AND && mode_i <= MD_NOR) || mode_i == MD_SLT || mode_i == MD_SLTU)
            p_no_carry_r10: assert (!carry_o && !ovf_o)
                else $error("flag raised in logic/compare code");
    end

endmodule

// File: tb/sim_alu_core.sv
// Bench: drives operand/code triples once per clock on the rising edge and
// compares all outputs against a behavioural model at the falling edge.
module sim_alu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic [3:0]  mode = '0;
    logic [31:0] result;
    logic        carry, ovf, zero;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #5 clk = ~clk;

    alu_core u0 (
        .a_i      (a),
        .b_i      (b),
        .mode_i   (mode),
        .result_o (result),
        .carry_o  (carry),
        .ovf_o    (ovf),
        .zero_o   (zero)
    );

    // Behavioural model of the requirements.
    task automatic model(input logic [31:0] x, input logic [31:0] y, input logic [3:0] m,
                         output logic [31:0] r, output logic c, output logic v, output logic z);
        longint sx, sy, full;
        logic [32:0] wide;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        r = '0; c = 1'b0; v = 1'b0; z = 1'b0;
        case (m)
            4'h0, 4'h1: begin
                wide = {1'b0, x} + {1'b0, y};
                r = wide[31:0]; c = wide[32];
                full = sx + sy;
                if (m == 4'h0) v = (full > 64'sd2147483647) || (full < -64'sd2147483648);
            end
            4'h2, 4'h3: begin
                wide = {1'b0, x} + {1'b0, ~y} + 33'd1;
                r = wide[31:0]; c = (x >= y);
                full = sx - sy;
                if (m == 4'h2) v = (full > 64'sd2147483647) || (full < -64'sd2147483648);
            end
            4'h4: r = x & y;
            4'h5: r = x | y;
            4'h6: r = x ^ y;
            4'h7: r = ~(x | y);
            4'hA: r = {31'd0, sx < sy};
            4'hB: r = {31'd0, x < y};
            default: ;
        endcase
        if (m <= 4'h7 || m == 4'hA || m == 4'hB) z = (r == 32'd0);
    endtask

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'h0, 4'h1: return "R1";
            4'h2, 4'h3: return "R2";
            4'h4, 4'h5, 4'h6, 4'h7: return "R5";
            4'hA: return "R6";
            4'hB: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h mode=%h actual=%h expected=%h", tag, a, b, mode, act, exp);
        end
    endtask

    // Apply one vector at the rising edge; compare at the falling edge.
    task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [3:0] m);
        logic [31:0] er;
        logic ec, ev, ez;
        @(posedge clk);
        a = x; b = y; mode = m;
        @(negedge clk);
        model(x, y, m, er, ec, ev, ez);
        check(tag_of(m), result, er);
        // R10: carry/overflow in logic and compare codes; R1/R2 carry otherwise
        check((m >= 4'h4) ? "R10" : tag_of(m), {31'd0, carry}, {31'd0, ec});
        // R4: mixed-sign signed add; R3 overflow otherwise
        check((m == 4'h0 && x[31] != y[31]) ? "R4" : "R3", {31'd0, ovf}, {31'd0, ev});
        check("R8", {31'd0, zero}, {31'd0, ez});
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    initial begin
        logic [31:0] corners [8];
        corners[0] = 32'h0000_0000;
        corners[1] = 32'h0000_0001;
        corners[2] = 32'h7FFF_FFFF;
        corners[3] = 32'h8000_0000;
        corners[4] = 32'hFFFF_FFFF;
        corners[5] = 32'h8000_0001;
        corners[6] = 32'h5555_AAAA;
        corners[7] = 32'h0F0F_F0F0;

        // Reset window: code 0 with zero operands gives zero result, zero flag set (R1, R8).
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", result, 32'd0);
        check("R8", {31'd0, zero}, 32'd1);
        @(posedge clk);
        rst_n = 1'b1;

        // Directed corners under every code (R1-R10).
        for (int m = 0; m < 16; m++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(corners[i], corners[j], 4'(m));

        // R6: signed compare where the subtraction overflows.
        apply(32'h8000_0000, 32'h0000_0001, 4'hA);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'hA);
        // R4: opposite-sign extremes under signed add.
        apply(32'h7FFF_FFFF, 32'h8000_0000, 4'h0);

        // Pseudo-random operands under every code.
        for (int k = 0; k < 300; k++) begin
            logic [31:0] x;
            step_lfsr(); x = lfsr;
            step_lfsr();
            for (int m = 0; m < 16; m++) apply(x, lfsr, 4'(m));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule